// File: doc/BRIEF.md
# Highway and Farm Road Traffic Controller

This block drives the signal lamps at a crossing where a busy highway meets a rarely used farm road. The highway keeps green by default. The farm road gets green only when a car waits at its sensor and the highway has already had its minimum green time. Two machines make up the design. A four-phase sequencer picks the lamp colours. A separate interval timer measures how long the current phase has lasted and raises a short flag and a long flag. The sequencer pulses a restart to the timer whenever the phase changes, so every phase is timed from its own start.

The car sensor is asynchronous to the clock. It passes through two flip-flops before the sequencer reads it. The lamp outputs come from registers. Both interval lengths are parameters counted in clock cycles. After a restart the short flag rises once `SHORT_CYCLES` cycles have passed and the long flag rises once `LONG_CYCLES` cycles have passed. So a yellow phase lasts `SHORT_CYCLES+1` clocks, and a green phase that runs to its timeout lasts `LONG_CYCLES+1` clocks.

Top module: `tlc_crossing`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, the highway lamp is green and the farm lamp is red. The timer is cleared.
- R2: Each lamp output uses the code 2'b00 for red, 2'b01 for yellow and 2'b10 for green. On every cycle at least one of the two lamps is red, and the lamps follow the phase:
  - highway green with farm red
  - highway yellow with farm red
  - farm green with highway red
  - farm yellow with highway red
- R3: Highway green holds until two conditions are both true: the synchronized sensor shows a car, and the long flag is set. Then the next cycle is highway yellow.
- R4: Highway yellow lasts exactly `SHORT_CYCLES+1` cycles and is followed by farm green.
- R5: Farm green moves to farm yellow on the cycle after the synchronized sensor shows no car or the long flag is set, whichever comes first. With a car present throughout, farm green lasts exactly `LONG_CYCLES+1` cycles.
- R6: Farm yellow lasts exactly `SHORT_CYCLES+1` cycles and is followed by highway green.
- R7: A change on `car_i` can first affect the lamps at the third rising clock edge after the change is applied.
- R8: The timer restarts at every phase change. Its short and long flags stay high until the next restart. A highway green entered with a car already waiting still lasts exactly `LONG_CYCLES+1` cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| car_i | input | 1 | Farm road car sensor, asynchronous |
| hwy_light_o | output | 2 | Highway lamp colour code (registered) |
| farm_light_o | output | 2 | Farm road lamp colour code (registered) |

## Verification
The lamps are registered straight from the next-phase decision, so a wrong phase shows at the ports on the very next cycle. A wrong timer count shows when a phase ends, as a yellow or green that is too long or too short. The bench therefore runs a cycle-accurate model next to the design and compares both lamps on every cycle. It also measures the length of each phase directly and checks the three-edge sensor latency. A stuck synchronizer stage or a missed restart shows as a phase boundary shifted by one or more cycles.

// File: rtl/tlc_pkg.sv
package tlc_pkg;

    typedef enum logic [1:0] {
        LT_RED = 2'b00,
        LT_YEL = 2'b01,
        LT_GRN = 2'b10
    } light_t;

    typedef enum logic [1:0] {
        PH_HWY_GO   = 2'd0,
        PH_HWY_WARN = 2'd1,
        PH_FRM_GO   = 2'd2,
        PH_FRM_WARN = 2'd3
    } phase_t;

    typedef struct packed {
        light_t hwy;
        light_t farm;
    } lamps_t;

    function automatic lamps_t lamps_for(phase_t p);
        lamps_t l;
        case (p)
            PH_HWY_GO:   begin l.hwy = LT_GRN; l.farm = LT_RED; end
            PH_HWY_WARN: begin l.hwy = LT_YEL; l.farm = LT_RED; end
            PH_FRM_GO:   begin l.hwy = LT_RED; l.farm = LT_GRN; end
            default:     begin l.hwy = LT_RED; l.farm = LT_YEL; end
        endcase
        return l;
    endfunction

endpackage

// File: rtl/tlc_sync.sv
module tlc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], async_i};
    end

    assign sync_o = chain_q[STAGES-1];

    // R7: the output is the input delayed by exactly STAGES edges
    a_r7_sync_delay: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> chain_q[STAGES-1] == $past(chain_q[STAGES-2]));

endmodule

// File: rtl/tlc_timer.sv
module tlc_timer #(
    parameter int SHORT_CYCLES = 3,
    parameter int LONG_CYCLES  = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic restart_i,
    output logic short_o,
    output logic long_o
);
    localparam int CNT_W = $clog2(LONG_CYCLES + 1);
    localparam logic [CNT_W-1:0] SHORT_V = CNT_W'(SHORT_CYCLES);
    localparam logic [CNT_W-1:0] LONG_V  = CNT_W'(LONG_CYCLES);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || restart_i)   cnt_q <= '0;
        else if (cnt_q != LONG_V) cnt_q <= cnt_q + 1'b1;
    end

    assign short_o = (cnt_q >= SHORT_V);
    assign long_o  = (cnt_q >= LONG_V);

    a_r8_restart_clears: assert property (@(posedge clk) disable iff (rst)
        restart_i |=> !short_o && !long_o);
    a_r8_long_implies_short: assert property (@(posedge clk) disable iff (rst)
        long_o |-> short_o);
    a_r8_flags_sticky: assert property (@(posedge clk) disable iff (rst)
        (long_o && !restart_i) |=> long_o);
    a_r1_timer_cleared: assert property (@(posedge clk)
        $past(rst) |-> cnt_q == '0);

endmodule

// File: rtl/tlc_sequencer.sv
module tlc_sequencer
    import tlc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   car_i,
    input  logic   short_i,
    input  logic   long_i,
    output logic   restart_o,
    output lamps_t lamps_o
);
    phase_t phase_q, phase_d;
    lamps_t lamps_q;

    always_comb begin
        phase_d = phase_q;
        case (phase_q)
            PH_HWY_GO:   if (car_i && long_i)   phase_d = PH_HWY_WARN;
            PH_HWY_WARN: if (short_i)           phase_d = PH_FRM_GO;
            PH_FRM_GO:   if (!car_i || long_i)  phase_d = PH_FRM_WARN;
            default:     if (short_i)           phase_d = PH_HWY_GO;
        endcase
    end

    assign restart_o = (phase_d != phase_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_HWY_GO;
            lamps_q <= lamps_for(PH_HWY_GO);
        end else begin
            phase_q <= phase_d;
            lamps_q <= lamps_for(phase_d);
        end
    end

    assign lamps_o = lamps_q;

    a_r2_one_red: assert property (@(posedge clk) disable iff (1'b0)
        !$isunknown(lamps_q) |-> (lamps_q.hwy == LT_RED || lamps_q.farm == LT_RED));
    a_r3_hold_green: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_HWY_GO && !(car_i && long_i)) |=> phase_q == PH_HWY_GO);
    a_r4_warn_hold: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_HWY_WARN && !short_i) |=> phase_q == PH_HWY_WARN);
    a_r5_farm_leave: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_FRM_GO && (!car_i || long_i)) |=> phase_q == PH_FRM_WARN);
    a_r6_back_home: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_FRM_WARN && short_i) |=> phase_q == PH_HWY_GO);

endmodule

// File: rtl/tlc_crossing.sv
module tlc_crossing
    import tlc_pkg::*;
#(
    parameter int SHORT_CYCLES = 3,
    parameter int LONG_CYCLES  = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       car_i,
    output logic [1:0] hwy_light_o,
    output logic [1:0] farm_light_o
);
    logic   car_s, restart, short_f, long_f;
    lamps_t lamps;

    tlc_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .async_i(car_i), .sync_o(car_s)
    );

    tlc_timer #(.SHORT_CYCLES(SHORT_CYCLES), .LONG_CYCLES(LONG_CYCLES)) u_timer (
        .clk(clk), .rst(rst), .restart_i(restart), .short_o(short_f), .long_o(long_f)
    );

    tlc_sequencer u_seq (
        .clk(clk), .rst(rst), .car_i(car_s), .short_i(short_f), .long_i(long_f),
        .restart_o(restart), .lamps_o(lamps)
    );

    assign hwy_light_o  = lamps.hwy;
    assign farm_light_o = lamps.farm;

    a_r1_reset_lamps: assert property (@(posedge clk)
        $past(rst) |-> (hwy_light_o == 2'b10 && farm_light_o == 2'b00));

endmodule

// File: tb/test_tlc_crossing.sv
module test_tlc_crossing;
    localparam int S = 3;
    localparam int L = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic car = 1'b0;
    logic [1:0] hwy, farm;
    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit lockstep = 1'b0;

    tlc_crossing #(.SHORT_CYCLES(S), .LONG_CYCLES(L)) i_tlc_crossing (
        .clk(clk), .rst(rst), .car_i(car), .hwy_light_o(hwy), .farm_light_o(farm)
    );

    always #5 clk = ~clk;

    // reference model: 0=hwy go,1=hwy warn,2=farm go,3=farm warn
    logic m_s1 = 1'b0, m_s2 = 1'b0;
    int m_ph = 0, m_cnt = 0;

    function automatic int next_phase(int ph, logic c, int cnt);
        case (ph)
            0: return (c && cnt >= L) ? 1 : 0;
            1: return (cnt >= S) ? 2 : 1;
            2: return (!c || cnt >= L) ? 3 : 2;
            default: return (cnt >= S) ? 0 : 3;
        endcase
    endfunction

    function automatic logic [1:0] exp_hwy(int ph);
        return (ph == 0) ? 2'b10 : (ph == 1) ? 2'b01 : 2'b00;
    endfunction

    function automatic logic [1:0] exp_farm(int ph);
        return (ph == 2) ? 2'b10 : (ph == 3) ? 2'b01 : 2'b00;
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst) begin
            m_s1 <= 1'b0; m_s2 <= 1'b0; m_ph <= 0; m_cnt <= 0;
        end else begin
            int nx;
            nx = next_phase(m_ph, m_s2, m_cnt);
            m_s1 <= car; m_s2 <= m_s1; m_ph <= nx;
            m_cnt <= (nx != m_ph) ? 0 : ((m_cnt < L) ? m_cnt + 1 : m_cnt);
        end
    end

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        if (lockstep) begin
            check(hwy == 2'b00 || farm == 2'b00, "R2 one red", {hwy, farm}, 0);
            check(hwy == exp_hwy(m_ph), "R2 hwy model", hwy, exp_hwy(m_ph));
            check(farm == exp_farm(m_ph), "R2 farm model", farm, exp_farm(m_ph));
        end
    end

    // count consecutive negedges (from the current one) where lamps match
    task automatic run_len(logic [1:0] h, logic [1:0] f, output int n);
        n = 0;
        while (hwy == h && farm == f) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int n;
        void'($urandom(32'd20240611));
        // R1: reset state
        repeat (3) @(negedge clk);
        check(hwy == 2'b10 && farm == 2'b00, "R1 in reset", {hwy, farm}, 4'b1000);
        rst = 1'b0;
        @(negedge clk);
        check(hwy == 2'b10 && farm == 2'b00, "R1 after reset", {hwy, farm}, 4'b1000);
        lockstep = 1'b1;
        // R3: no car, highway green holds
        repeat (3 * L) @(negedge clk);
        check(hwy == 2'b10, "R3 hold without car", hwy, 2);
        // R7: car applied now, lamps change at third edge
        car = 1'b1;
        @(negedge clk); check(hwy == 2'b10, "R7 edge1", hwy, 2);
        @(negedge clk); check(hwy == 2'b10, "R7 edge2", hwy, 2);
        @(negedge clk); check(hwy == 2'b01, "R7 edge3", hwy, 1);
        // R4 yellow length
        run_len(2'b01, 2'b00, n);
        check(n == S + 1, "R4 hwy yellow length", n, S + 1);
        check(farm == 2'b10, "R4 then farm green", farm, 2);
        // R5 farm green with car held: long timeout
        run_len(2'b00, 2'b10, n);
        check(n == L + 1, "R5 farm green length", n, L + 1);
        // R6 farm yellow
        run_len(2'b00, 2'b01, n);
        check(n == S + 1, "R6 farm yellow length", n, S + 1);
        check(hwy == 2'b10, "R6 back to hwy green", hwy, 2);
        // R8 car already waiting: full restart of long interval
        run_len(2'b10, 2'b00, n);
        check(n == L + 1, "R8 hwy green restarted", n, L + 1);
        // R5 car leaves early in farm green
        run_len(2'b01, 2'b00, n);
        @(negedge clk); car = 1'b0;
        // sensor low reaches sequencer after 2 edges, phase changes on the 3rd
        @(negedge clk); @(negedge clk); check(farm == 2'b10, "R5 still green", farm, 2);
        @(negedge clk); check(farm == 2'b01, "R5 early exit", farm, 1);
        // random traffic against the model
        for (int seg = 0; seg < 150; seg++) begin
            int len;
            len = 1 + int'($urandom_range(24));
            car = ($urandom_range(99) < 45);
            repeat (len) @(negedge clk);
        end
        // mid-run reset: R1
        rst = 1'b1;
        @(negedge clk);
        check(hwy == 2'b10 && farm == 2'b00, "R1 mid-run reset", {hwy, farm}, 4'b1000);
        rst = 1'b0; car = 1'b1;
        repeat (40) @(negedge clk);
        lockstep = 1'b0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule